// File: doc/BRIEF.md
# Keyboard/Mouse Port Register Front End

This block is the software-visible side of a keyboard or mouse serial port controller. A processor reaches it through a simple word-wide bus with separate read and write strobes and a 12-bit byte address covering a 4 KB window. Inside are a control word, a clock-divider word, a read-only status view, a data port, an interrupt-status view, and an eight-word identification area at the very top of the window.

The receive side hands over whole bytes with a one-cycle valid pulse. Each byte is held and flagged as pending until software reads the data port. A read of the data port always returns a byte. When one is pending, that read takes the new byte and clears the flag. When none is pending, it returns the last byte it delivered. A write to the data port sends the low byte to the transmit side as a one-cycle strobe. One level interrupt is produced from the pending flag and two control bits. The line-level serial logic is outside this block.

Reads are combinational: `bus_rdata` is valid in the same cycle as `bus_rd`, and reads as zero when `bus_rd` is low. Side effects of a read and every register update take place at the next rising clock edge.

Top module: `kmi_regfile`

## Requirements
- R1: After reset, control and clock-divider read 0x0, status reads 0x40, interrupt-status reads 0x2, `irq` is low and `tx_strobe` is low.
- R2: A write to byte address 0x000 (control) or 0x00C (clock divider) stores all 32 bits of `bus_wdata`, and the stored value reads back from the same address.
- R3: A `rx_valid` pulse sets the pending flag. The flag shows as status bit 4 (address 0x004) and as interrupt-status bit 0 (address 0x010). Interrupt-status bit 1 always reads 1.
- R4: A read of address 0x008 while a byte is pending returns that byte in bits 7:0 and clears the flag. A read with nothing pending returns the last delivered byte again and changes nothing.
- R5: When a data-port read and a `rx_valid` pulse occur in the same cycle, the read returns the byte that was already pending and the flag stays set. The new byte is then returned by the next data-port read.
- R6: Status bit 6 always reads 1. Status bit 2 is the XOR of the 8 bits of the last byte returned by a data-port read. Status bits 5, 3, 1 and 0 and bits 31:7 read 0.
- R7: `irq` is high exactly when control bit 3 is set, or when control bit 4 is set and a byte is pending. It follows a control write from the next cycle on.
- R8: A write to address 0x008 raises `tx_strobe` for exactly one cycle, the cycle after the write, with `bus_wdata[7:0]` on `tx_byte` in that cycle.
- R9: A read at address 0xFE0 + 4*k, for k = 0 to 7, returns in bits 7:0 the k-th entry of 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, with the upper bits zero.
- R10: A read of any other address returns 0. This includes unaligned addresses below 0xFE0 and addresses from 0x014 to 0xFDF. Writes to those addresses, and to status and interrupt-status, change no register and raise no `tx_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| rx_valid | input | 1 | One-cycle pulse: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| tx_strobe | output | 1 | One-cycle pulse: `tx_byte` is to be sent |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a data-port read that lands in the same clock cycle as a receive pulse. It only occurs when the bus and the receive side line up to the cycle. The bench arranges it by driving `bus_rd` at the data address and `rx_valid` with a second byte on the same falling edge, while a first byte is still pending. It then expects the first byte on that read, a status that still shows the flag set, and the second byte on the following read. The parity bit is checked after bytes with an odd and with an even number of ones, and an undefined-address write is followed by read-backs of every writable register.

// File: rtl/kmi_pkg.sv
// Package: shared constants, the read selector type and the identification table.
// Assumes byte addressing with 32-bit words, and a 4 KB window whose top
// 32 bytes hold the identification words.
package kmi_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ID_WORDS = 8;

    // Byte offsets of the registers (the behaviour depends on these)
    localparam int unsigned OFF_CTRL  = 'h000;
    localparam int unsigned OFF_STAT  = 'h004;
    localparam int unsigned OFF_DATA  = 'h008;
    localparam int unsigned OFF_CDIV  = 'h00C;
    localparam int unsigned OFF_ISTAT = 'h010;

    // Bit positions in the status word
    localparam int unsigned ST_TX_EMPTY = 6;
    localparam int unsigned ST_RX_FULL  = 4;
    localparam int unsigned ST_PARITY   = 2;

    // Bit positions in the control word
    localparam int unsigned CR_FORCE_IRQ = 3;
    localparam int unsigned CR_RX_IRQ_EN = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_DATA,
        SEL_CDIV,
        SEL_ISTAT,
        SEL_ID
    } reg_sel_e;

    // Identification byte for word k of the top window
    function automatic logic [BYTE_W-1:0] id_byte(input logic [2:0] k);
        case (k)
            3'd0:    id_byte = 8'h50;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/kmi_addr_decode.sv
// Address decoder: maps a byte address to a register selector and an
// identification word index.
// Assumes the registers match on the exact byte address, and that the
// identification area is the top 32 bytes of the window.
module kmi_addr_decode
    import kmi_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [2:0]        id_idx
);

    localparam int unsigned ID_BASE = (1 << ADDR_W) - 4 * ID_WORDS;

    // Purpose: choose the register the address names
    always_comb begin
        id_idx = addr[4:2];
        if (addr >= ADDR_W'(ID_BASE)) begin
            sel = SEL_ID;
        end else begin
            case (addr)
                ADDR_W'(OFF_CTRL):  sel = SEL_CTRL;
                ADDR_W'(OFF_STAT):  sel = SEL_STAT;
                ADDR_W'(OFF_DATA):  sel = SEL_DATA;
                ADDR_W'(OFF_CDIV):  sel = SEL_CDIV;
                ADDR_W'(OFF_ISTAT): sel = SEL_ISTAT;
                default:            sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/kmi_rx_hold.sv
// Receive holder: keeps the incoming byte and its pending flag, and keeps the
// last byte delivered to software together with that byte's parity.
// Assumes rx_valid is a one-cycle pulse. A byte arriving while one is
// already pending replaces it. An arrival wins over a pop in the same cycle.
module kmi_rx_hold
    import kmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              pop,
    output logic              pending,
    output logic [BYTE_W-1:0] read_byte,
    output logic              last_parity
);

    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] last_q;
    logic              pend_q;

    // Purpose: capture arrivals and clear the flag on a pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            pend_q <= 1'b0;
        end else if (rx_valid) begin
            hold_q <= rx_byte;
            pend_q <= 1'b1;
        end else if (pop) begin
            pend_q <= 1'b0;
        end
    end

    // Purpose: remember the byte handed out by a popping read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (pop && pend_q) begin
            last_q <= hold_q;
        end
    end

    // Purpose: present the byte a data read would return now
    always_comb begin
        read_byte   = pend_q ? hold_q : last_q;
        last_parity = ^last_q;
        pending     = pend_q;
    end

endmodule

// File: rtl/kmi_irq_gen.sv
// Interrupt combiner: produces the level interrupt from the pending flag and
// the two interrupt bits of the control word.
// Assumes all inputs are register outputs, so irq is free of glitches.
module kmi_irq_gen (
    input  logic rx_irq_en,
    input  logic force_irq,
    input  logic pending,
    output logic irq
);

    // Purpose: combine the enabled receive source with the forcing bit
    always_comb begin
        irq = force_irq | (rx_irq_en & pending);
    end

endmodule

// File: rtl/kmi_regfile.sv
// Register front end for a keyboard/mouse serial port. It decodes bus reads
// and writes, holds the control and clock-divider words, forms the read data
// and issues transmit bytes.
// Assumes single-cycle bus strobes, reads answered combinationally in the
// strobe cycle, and side effects taken at the following clock edge.
module kmi_regfile
    import kmi_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);

    reg_sel_e          sel;
    logic [2:0]        id_idx;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] cdiv_q;
    logic              rx_pending;
    logic [BYTE_W-1:0] rx_read_byte;
    logic              rx_parity;
    logic              data_pop;

    kmi_addr_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr   (bus_addr),
        .sel    (sel),
        .id_idx (id_idx)
    );

    // Purpose: a data-port read consumes a pending byte
    always_comb begin
        data_pop = bus_rd && (sel == SEL_DATA);
    end

    kmi_rx_hold u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .pop         (data_pop),
        .pending     (rx_pending),
        .read_byte   (rx_read_byte),
        .last_parity (rx_parity)
    );

    kmi_irq_gen u_irq (
        .rx_irq_en (ctrl_q[CR_RX_IRQ_EN]),
        .force_irq (ctrl_q[CR_FORCE_IRQ]),
        .pending   (rx_pending),
        .irq       (irq)
    );

    // Purpose: store the control and clock-divider words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cdiv_q <= '0;
        end else if (bus_wr) begin
            if (sel == SEL_CTRL) ctrl_q <= bus_wdata;
            if (sel == SEL_CDIV) cdiv_q <= bus_wdata;
        end
    end

    // Purpose: turn a data-port write into a one-cycle transmit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
        end else begin
            tx_strobe <= bus_wr && (sel == SEL_DATA);
            if (bus_wr && (sel == SEL_DATA)) tx_byte <= bus_wdata[BYTE_W-1:0];
        end
    end

    // Purpose: form the read data for the selected register
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_CTRL: bus_rdata = ctrl_q;
                SEL_STAT: begin
                    bus_rdata[ST_TX_EMPTY] = 1'b1;
                    bus_rdata[ST_RX_FULL]  = rx_pending;
                    bus_rdata[ST_PARITY]   = rx_parity;
                end
                SEL_DATA:  bus_rdata[BYTE_W-1:0] = rx_read_byte;
                SEL_CDIV:  bus_rdata = cdiv_q;
                SEL_ISTAT: bus_rdata[1:0] = {1'b1, rx_pending};
                SEL_ID:    bus_rdata[BYTE_W-1:0] = id_byte(id_idx);
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/kmi_regfile_checker.sv
// Checker: temporal properties of the register front end, bound to the top.
// Assumes the pending flag and the control word are reachable by name in the
// bound instance.
module kmi_regfile_checker #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        wdata_lo,
    input logic              rx_valid,
    input logic              tx_strobe,
    input logic [7:0]        tx_byte,
    input logic              irq,
    input logic              pending,
    input logic [1:0]        ctrl_irq
);

    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(kmi_pkg::OFF_DATA);

    // R8: a data write produces the strobe and byte in the next cycle
    p_tx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_A) |=> (tx_strobe && tx_byte == $past(wdata_lo)));

    // R10: the strobe only ever follows a data-port write
    p_tx_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(bus_wr && bus_addr == DATA_A));

    // R3: an arriving byte always leaves the flag set
    p_rx_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> pending);

    // R4: a data read with no arrival clears the flag
    p_pop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DATA_A && !rx_valid) |=> !pending);

    // R7: the forcing control bit holds the interrupt high
    p_force_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_irq[0] |-> irq);

    // R7: no source means no interrupt
    p_quiet_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_irq[0] && !pending) |-> !irq);

endmodule

bind kmi_regfile kmi_regfile_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .wdata_lo  (bus_wdata[7:0]),
    .rx_valid  (rx_valid),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte),
    .irq       (irq),
    .pending   (rx_pending),
    .ctrl_irq  ({ctrl_q[4], ctrl_q[3]})
);

// File: tb/kmi_regfile_bench.sv
// Scoreboard bench: read tasks queue the expected data and a monitor compares
// it with bus_rdata 2 ns after each falling edge at which a read is driven.
module kmi_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_strobe;
    logic [7:0]  tx_byte;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    kmi_regfile u_kmi_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_strobe (tx_strobe),
        .tx_byte   (tx_byte),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_rx(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Monitor: pop and compare one expected item for each read cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (bus_rd) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL scoreboard read with no expectation actual 0x%08h expected none",
                             bus_rdata);
                end else begin
                    chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [7:0] ID_TAB [8] = '{8'h50, 8'h10, 8'h04, 8'h00,
                                          8'h0D, 8'hF0, 8'h05, 8'hB1};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        do_read(12'h000, 32'h0,  "R1 control");
        do_read(12'h004, 32'h40, "R1 status");
        do_read(12'h010, 32'h2,  "R1 intstat");
        do_read(12'h00C, 32'h0,  "R1 clkdiv");
        #2;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 tx_strobe", {31'b0, tx_strobe}, 32'h0);

        // R2: write and read back
        do_write(12'h000, 32'h0000_0010);
        do_read(12'h000, 32'h10, "R2 control");
        do_write(12'h00C, 32'hDEAD_BEEF);
        do_read(12'h00C, 32'hDEAD_BEEF, "R2 clkdiv");
        #2;
        chk("R7 irq enabled no byte", {31'b0, irq}, 32'h0);

        // R3: arrival sets the flag
        do_rx(8'h07);
        do_read(12'h004, 32'h50, "R3 status full");
        do_read(12'h010, 32'h3,  "R3 intstat");
        #2;
        chk("R7 irq enabled with byte", {31'b0, irq}, 32'h1);

        // R4 and R6: pop, then repeat read
        do_read(12'h008, 32'h07, "R4 data pop");
        do_read(12'h004, 32'h44, "R6 status odd parity");
        #2;
        chk("R7 irq after pop", {31'b0, irq}, 32'h0);
        do_read(12'h008, 32'h07, "R4 data repeat");
        do_read(12'h010, 32'h2,  "R4 intstat cleared");

        // R7: forcing bit
        do_write(12'h000, 32'h0000_0008);
        #2;
        chk("R7 irq forced", {31'b0, irq}, 32'h1);
        do_write(12'h000, 32'h0);
        #2;
        chk("R7 irq released", {31'b0, irq}, 32'h0);

        // R5: read and arrival in the same cycle
        do_rx(8'h5A);
        @(negedge clk);
        exp_q.push_back(32'h5A);
        tag_q.push_back("R5 collide read");
        bus_addr = 12'h008;
        bus_rd   = 1'b1;
        rx_valid = 1'b1;
        rx_byte  = 8'h83;
        @(negedge clk);
        bus_rd   = 1'b0;
        rx_valid = 1'b0;
        do_read(12'h004, 32'h50, "R5 status still full");
        do_read(12'h008, 32'h83, "R5 second byte");
        do_read(12'h004, 32'h44, "R6 status after 0x83");
        do_rx(8'h81);
        do_read(12'h008, 32'h81, "R4 data 0x81");
        do_read(12'h004, 32'h40, "R6 status even parity");

        // R8: transmit strobe
        do_write(12'h008, 32'h1234_56A5);
        #2;
        chk("R8 strobe high", {31'b0, tx_strobe}, 32'h1);
        chk("R8 byte", {24'b0, tx_byte}, 32'hA5);
        @(negedge clk);
        #2;
        chk("R8 strobe one cycle", {31'b0, tx_strobe}, 32'h0);

        // R9: identification window
        for (int k = 0; k < 8; k++) begin
            do_read(12'hFE0 + 12'(4 * k), {24'b0, ID_TAB[k]}, $sformatf("R9 id %0d", k));
        end

        // R10: undefined addresses
        do_write(12'h000, 32'h0000_0010);
        do_read(12'h014, 32'h0, "R10 read 0x014");
        do_read(12'h800, 32'h0, "R10 read 0x800");
        do_read(12'h009, 32'h0, "R10 read unaligned");
        do_write(12'h014, 32'h0000_0018);
        #2;
        chk("R10 no strobe", {31'b0, tx_strobe}, 32'h0);
        do_write(12'h004, 32'hFFFF_FFFF);
        do_write(12'h010, 32'hFFFF_FFFF);
        do_write(12'h00D, 32'h0000_0001);
        do_read(12'h000, 32'h10, "R10 control unchanged");
        do_read(12'h00C, 32'hDEAD_BEEF, "R10 clkdiv unchanged");
        do_read(12'h010, 32'h2, "R10 intstat unchanged");
        do_read(12'h004, 32'h40, "R10 status unchanged");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard leftover actual %0d expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule